// File: doc/BRIEF.md
# Byte-Wide Histogram Host Port

This block lets a host computer reach the histogram memory of a pulse-height analyser through a narrow 8-bit bus. Each memory word holds one channel count of 24 bits. The host first sets a 13-bit channel address by writing a low byte and a high byte, each through its own decoded select. It then moves count data through a third select, one byte for each strobe. Three strobes make one word, least significant byte first. After the third byte the address steps to the next channel, so a whole spectrum can be streamed without reloading the address.

Reads are prefetched. Whenever the address changes, the port fetches the addressed word into a holding register, so data-select reads are answered in the same cycle. Writes are collected byte by byte. After the third byte the port performs one memory write cycle. The memory is written when its output enable is low and its read/write line is high. It is read when both lines are low.

Acquisition has priority over the memory. While the acquisition side raises its ownership line, the port starts no memory cycle. It also raises its busy status, and it ignores every host strobe. A port-select input chooses the transfer direction. A direction output steers the external bus transceiver. The data-out enable stands for the tri-state drive of the bus.

Top module: `byte_host_port`

## Requirements
- R1: While reset is held, `busy` is 1 and `host_doe` is 0. After reset the address is 0, and the first word is fetched before `busy` falls.
- R2: An accepted strobe with `rd_sel`=0 and `sel_lo`=1 loads `host_din` into address bits 7..0. With `sel_hi`=1 it loads address bits 12..8. Either load causes the word at the new address to be fetched.
- R3: On a high-address load, only `host_din` bits 4..0 are used. Bits 7..5 have no effect on the address.
- R4: Accepted strobes with `rd_sel`=1 and `sel_data`=1 return the 24-bit count of the current address on `host_dout` in the same cycle. The bytes come out in the order 7..0, then 15..8, then 23..16.
- R5: After the third byte of a read or a write, the address increments by one. It wraps from 8191 to 0.
- R6: Three accepted strobes with `rd_sel`=0 and `sel_data`=1 collect a word, least significant byte first. The port then writes it with one cycle of `mem_oe_n`=0 and `mem_rw`=1 at the current address.
- R7: `host_doe` is 1 only in a cycle with `strobe`=1, `rd_sel`=1, `sel_data`=1 and `busy`=0. `xcvr_dir` is 1 (toward the host) exactly when `rd_sel`=1 and any select is active.
- R8: While `acq_own` is 1, `busy` is 1, `mem_oe_n` stays 1, and host strobes change neither the address nor the byte position. After a fetch cycle the port spends one more busy cycle before it serves data.
- R9: Any address load restarts the byte position, so the next data read returns bits 7..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | One-cycle host transfer strobe |
| rd_sel | input | 1 | Port select: 1 = host reads, 0 = host writes |
| sel_lo | input | 1 | Decoded select, low address byte |
| sel_hi | input | 1 | Decoded select, high address byte |
| sel_data | input | 1 | Decoded select, count data byte |
| host_din | input | 8 | Byte from host |
| host_dout | output | 8 | Byte to host |
| host_doe | output | 1 | Drive enable for the host bus |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward host |
| busy | output | 1 | Host access refused this cycle |
| acq_own | input | 1 | Acquisition holds the memory |
| mem_addr | output | 13 | Memory address |
| mem_wdata | output | 24 | Memory write data |
| mem_rdata | input | 24 | Memory read data, valid one cycle after a read cycle |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_rw | output | 1 | Memory read/write, 1 = write when enabled |

## Verification
The bench builds the port with its default widths: a 13-bit address, 24-bit counts and an 8-bit bus. With these widths the high-address byte has 3 unused bits, and each word takes three strobes. The 8192-entry bench memory makes the wrap from the last channel to channel 0 reachable in a single address load. A behavioural model keeps the expected address, byte position and memory contents. Each cycle it checks the bus enable, the direction and the refusal behaviour during acquisition ownership.

// File: rtl/bhp_pkg.sv
package bhp_pkg;
    typedef enum logic [1:0] {
        ST_FETCH,
        ST_LATCH,
        ST_READY,
        ST_WRITE
    } port_state_t;
endpackage

// File: rtl/bhp_addr_reg.sv
module bhp_addr_reg #(
    parameter int ADDR_W = 13,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              bump,
    input  logic [BUS_W-1:0]  din,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - BUS_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load_lo) begin
            addr[BUS_W-1:0] <= din;
        end else if (load_hi) begin
            // only the bits that exist in the address are taken
            addr[ADDR_W-1:BUS_W] <= din[HI_W-1:0];
        end else if (bump) begin
            addr <= addr + {{(ADDR_W-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/bhp_byte_lanes.sv
module bhp_byte_lanes #(
    parameter int CNT_W = 24,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_idx,
    input  logic             capture,
    input  logic             rd_step,
    input  logic             wr_step,
    input  logic [BUS_W-1:0] din,
    input  logic [CNT_W-1:0] rdata,
    output logic [BUS_W-1:0] rd_byte,
    output logic [CNT_W-1:0] wdata,
    output logic             at_last
);
    localparam int NB    = CNT_W / BUS_W;
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NB - 1);

    logic [IDX_W-1:0] idx;
    logic [BUS_W-1:0] hold_lane [NB];
    logic [BUS_W-1:0] asm_lane  [NB];

    assign at_last = (idx == LAST);
    assign rd_byte = hold_lane[idx];

    always_ff @(posedge clk) begin
        if (!rst_n || clr_idx) begin
            idx <= '0;
        end else if (rd_step || wr_step) begin
            idx <= at_last ? '0 : idx + {{(IDX_W-1){1'b0}}, 1'b1};
        end
    end

    for (genvar g = 0; g < NB; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_lane[g] <= '0;
            end else if (capture) begin
                hold_lane[g] <= rdata[g*BUS_W +: BUS_W];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                asm_lane[g] <= '0;
            end else if (wr_step && idx == IDX_W'(g)) begin
                asm_lane[g] <= din;
            end
        end

        assign wdata[g*BUS_W +: BUS_W] = asm_lane[g];
    end
endmodule

// File: rtl/bhp_ctrl_fsm.sv
module bhp_ctrl_fsm
    import bhp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acq_own,
    input  logic reload,
    input  logic rd_wrap,
    input  logic wr_wrap,
    output logic busy,
    output logic capture,
    output logic bump,
    output logic mem_oe_n,
    output logic mem_rw
);
    port_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH: if (!acq_own) state_nx = ST_LATCH;
            ST_LATCH: state_nx = ST_READY;
            ST_READY: begin
                if (reload || rd_wrap) begin
                    state_nx = ST_FETCH;
                end else if (wr_wrap) begin
                    state_nx = ST_WRITE;
                end
            end
            ST_WRITE: if (!acq_own) state_nx = ST_FETCH;
            default:  state_nx = ST_FETCH;
        endcase
    end

    assign busy = acq_own || (state != ST_READY);

    always_comb begin
        mem_oe_n = 1'b1;
        mem_rw   = 1'b0;
        capture  = 1'b0;
        bump     = 1'b0;
        unique case (state)
            ST_FETCH: mem_oe_n = acq_own;
            ST_LATCH: capture = 1'b1;
            ST_READY: bump = rd_wrap;
            ST_WRITE: begin
                if (!acq_own) begin
                    mem_oe_n = 1'b0;
                    mem_rw   = 1'b1;
                    bump     = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/byte_host_port.sv
module byte_host_port #(
    parameter int ADDR_W = 13,
    parameter int CNT_W  = 24,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              rd_sel,
    input  logic              sel_lo,
    input  logic              sel_hi,
    input  logic              sel_data,
    input  logic [BUS_W-1:0]  host_din,
    output logic [BUS_W-1:0]  host_dout,
    output logic              host_doe,
    output logic              xcvr_dir,
    output logic              busy,
    input  logic              acq_own,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CNT_W-1:0]  mem_wdata,
    input  logic [CNT_W-1:0]  mem_rdata,
    output logic              mem_oe_n,
    output logic              mem_rw
);
    logic accept, load_lo, load_hi, reload;
    logic rd_step, wr_step, at_last;
    logic capture, bump;
    logic [BUS_W-1:0] rd_byte;

    assign accept   = strobe && !busy;
    assign load_lo  = accept && !rd_sel && sel_lo;
    assign load_hi  = accept && !rd_sel && sel_hi && !sel_lo;
    assign reload   = load_lo || load_hi;
    assign rd_step  = accept && rd_sel && sel_data;
    assign wr_step  = accept && !rd_sel && sel_data && !reload;

    assign host_doe  = rd_step;
    assign host_dout = rd_step ? rd_byte : '0;
    assign xcvr_dir  = rd_sel && (sel_lo || sel_hi || sel_data);

    bhp_addr_reg #(
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_lo (load_lo),
        .load_hi (load_hi),
        .bump    (bump),
        .din     (host_din),
        .addr    (mem_addr)
    );

    bhp_byte_lanes #(
        .CNT_W (CNT_W),
        .BUS_W (BUS_W)
    ) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_idx (reload),
        .capture (capture),
        .rd_step (rd_step),
        .wr_step (wr_step),
        .din     (host_din),
        .rdata   (mem_rdata),
        .rd_byte (rd_byte),
        .wdata   (mem_wdata),
        .at_last (at_last)
    );

    bhp_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .acq_own  (acq_own),
        .reload   (reload),
        .rd_wrap  (rd_step && at_last),
        .wr_wrap  (wr_step && at_last),
        .busy     (busy),
        .capture  (capture),
        .bump     (bump),
        .mem_oe_n (mem_oe_n),
        .mem_rw   (mem_rw)
    );
endmodule

// File: rtl/bhp_checker.sv
module bhp_checker #(
    parameter int ADDR_W = 13,
    parameter int BUS_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe,
    input logic              rd_sel,
    input logic              sel_lo,
    input logic              sel_hi,
    input logic              sel_data,
    input logic [BUS_W-1:0]  host_din,
    input logic              host_doe,
    input logic              xcvr_dir,
    input logic              busy,
    input logic              acq_own,
    input logic              mem_oe_n,
    input logic              mem_rw,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int HI_W = ADDR_W - BUS_W;

    AST_DOE_WITH_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        host_doe |-> xcvr_dir); // R7

    AST_DOE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        host_doe |-> (!acq_own && strobe)); // R7

    AST_NO_MEM_IN_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        acq_own |-> (mem_oe_n && busy)); // R8

    AST_LATCH_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && !mem_rw) |=> (mem_oe_n && busy)); // R8

    AST_HI_BITS_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !busy && !rd_sel && sel_hi && !sel_lo)
        |=> (mem_addr[ADDR_W-1:BUS_W] == $past(host_din[HI_W-1:0]))); // R3

    AST_STEP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && mem_rw)
        |=> (mem_addr == $past(mem_addr) + {{(ADDR_W-1){1'b0}}, 1'b1})); // R5
endmodule

bind byte_host_port bhp_checker #(
    .ADDR_W (ADDR_W),
    .BUS_W  (BUS_W)
) u_bhp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .rd_sel   (rd_sel),
    .sel_lo   (sel_lo),
    .sel_hi   (sel_hi),
    .sel_data (sel_data),
    .host_din (host_din),
    .host_doe (host_doe),
    .xcvr_dir (xcvr_dir),
    .busy     (busy),
    .acq_own  (acq_own),
    .mem_oe_n (mem_oe_n),
    .mem_rw   (mem_rw),
    .mem_addr (mem_addr)
);

// File: tb/test_byte_host_port.sv
module test_byte_host_port;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0, rd_sel = 1'b0, sel_lo = 1'b0, sel_hi = 1'b0, sel_data = 1'b0;
    logic [7:0]  host_din = '0;
    logic [7:0]  host_dout;
    logic        host_doe, xcvr_dir, busy;
    logic        acq_own = 1'b0;
    logic [12:0] mem_addr;
    logic [23:0] mem_wdata;
    logic [23:0] mem_rdata = '0;
    logic        mem_oe_n, mem_rw;

    logic [23:0] mem     [DEPTH];
    logic [23:0] ref_mem [DEPTH];
    int model_addr = 0;
    int model_idx  = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] smp_dout;
    logic       smp_doe, smp_dir;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_host_port i_byte_host_port (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .rd_sel(rd_sel),
        .sel_lo(sel_lo), .sel_hi(sel_hi), .sel_data(sel_data),
        .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe),
        .xcvr_dir(xcvr_dir), .busy(busy), .acq_own(acq_own),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_oe_n(mem_oe_n), .mem_rw(mem_rw)
    );

    // behavioural memory: registered read, write on enable with rw high
    always @(posedge clk) begin
        if (!mem_oe_n) begin
            if (mem_rw) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the port rules
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (acq_own) begin
                chk(busy && mem_oe_n && !host_doe, "R8 refuse during ownership",
                    {busy, mem_oe_n, host_doe}, 3'b110);
            end
            if (strobe || host_doe) begin
                chk(host_doe == (strobe && rd_sel && sel_data && !busy),
                    "R7 bus enable", host_doe, strobe && rd_sel && sel_data && !busy);
                chk(xcvr_dir == (rd_sel && (sel_lo || sel_hi || sel_data)),
                    "R7 direction", xcvr_dir, rd_sel && (sel_lo || sel_hi || sel_data));
            end
        end
    end

    task automatic wait_free();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic pulse(input bit lo, input bit hi, input bit dat, input bit rd,
                         input logic [7:0] d, input bit wait_first);
        if (wait_first) wait_free();
        @(posedge clk); #1;
        strobe = 1'b1; sel_lo = lo; sel_hi = hi; sel_data = dat; rd_sel = rd; host_din = d;
        @(negedge clk);
        smp_dout = host_dout; smp_doe = host_doe; smp_dir = xcvr_dir;
        @(posedge clk); #1;
        strobe = 1'b0; sel_lo = 1'b0; sel_hi = 1'b0; sel_data = 1'b0; rd_sel = 1'b0;
    endtask

    task automatic load_addr(input int a, input logic [2:0] junk);
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 8'(a), 1'b1);
        pulse(1'b0, 1'b1, 1'b0, 1'b0, {junk, 5'(a >> 8)}, 1'b1);
        model_addr = a % DEPTH;
        model_idx  = 0;
    endtask

    task automatic read_byte(input string req);
        logic [7:0] exp;
        exp = 8'(ref_mem[model_addr] >> (8 * model_idx));
        pulse(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1);
        chk(smp_doe && smp_dir && smp_dout == exp, req, smp_dout, exp);
        model_idx++;
        if (model_idx == 3) begin
            model_idx  = 0;
            model_addr = (model_addr + 1) % DEPTH;
        end
    endtask

    task automatic write_word(input logic [23:0] w);
        for (int b = 0; b < 3; b++) pulse(1'b0, 1'b0, 1'b1, 1'b0, 8'(w >> (8 * b)), 1'b1);
        ref_mem[model_addr] = w;
        model_addr = (model_addr + 1) % DEPTH;
        model_idx  = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]     = 24'(i * 40503 + 24'h1357);
            ref_mem[i] = mem[i];
        end
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R1 busy in reset", busy, 1);
        chk(host_doe == 1'b0, "R1 bus idle in reset", host_doe, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        wait_free();
        chk(mem_addr == 13'd0, "R1 address after reset", mem_addr, 0);
        // R4: three bytes of channel 0, then R5 increment
        for (int k = 0; k < 3; k++) read_byte("R4 byte order channel 0");
        wait_free();
        chk(mem_addr == 13'd1, "R5 increment after read", mem_addr, 1);
        for (int k = 0; k < 3; k++) read_byte("R5 next channel data");
        // R2: address load
        load_addr(13'h1234, 3'b000);
        wait_free();
        chk(mem_addr == 13'h1234, "R2 address load", mem_addr, 13'h1234);
        for (int k = 0; k < 3; k++) read_byte("R2 data at loaded address");
        // R3: junk high bits ignored
        load_addr(13'h0F05, 3'b111);
        wait_free();
        chk(mem_addr == 13'h0F05, "R3 high bits ignored", mem_addr, 13'h0F05);
        read_byte("R3 data at masked address");
        // R9: reload restarts byte position
        load_addr(13'h0F05, 3'b010);
        for (int k = 0; k < 3; k++) read_byte("R9 restart at low byte");
        // R6: write path and read-back
        load_addr(13'h0100, 3'b000);
        write_word(24'hA5C3E1);
        wait_free();
        chk(mem[13'h0100] == 24'hA5C3E1, "R6 memory written", mem[13'h0100], 24'hA5C3E1);
        chk(mem_addr == 13'h0101, "R5 increment after write", mem_addr, 13'h0101);
        read_byte("R6 read after write continues");
        load_addr(13'h0100, 3'b000);
        for (int k = 0; k < 3; k++) read_byte("R6 read back written word");
        // R5: wrap from last channel
        load_addr(13'h1FFF, 3'b000);
        for (int k = 0; k < 3; k++) read_byte("R5 last channel");
        wait_free();
        chk(mem_addr == 13'd0, "R5 wrap to zero", mem_addr, 0);
        read_byte("R5 data after wrap");
        // R8: strobes refused while acquisition owns memory
        @(posedge clk); #1 acq_own = 1'b1;
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 8'h77, 1'b0);
        pulse(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
        chk(!smp_doe, "R8 read refused", smp_doe, 0);
        pulse(1'b0, 1'b0, 1'b1, 1'b0, 8'h55, 1'b0);
        @(posedge clk); #1 acq_own = 1'b0;
        wait_free();
        chk(mem_addr == 13'(model_addr), "R8 address untouched", mem_addr, model_addr);
        read_byte("R8 byte position untouched");
        read_byte("R8 byte position untouched");
        // R8: ownership during a fetch delays it
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 8'h42, 1'b1);
        #1 acq_own = 1'b1;
        repeat (5) @(posedge clk);
        #1 acq_own = 1'b0;
        model_addr = (model_addr & 32'h1F00) | 32'h42;
        model_idx  = 0;
        for (int k = 0; k < 3; k++) read_byte("R8 fetch after ownership");
        // R7: no drive for writes or address-select reads
        pulse(1'b1, 1'b0, 1'b0, 1'b1, 8'h99, 1'b1);
        chk(!smp_doe && smp_dir, "R7 address select read no drive", {smp_doe, smp_dir}, 2'b01);
        pulse(1'b0, 1'b0, 1'b1, 1'b0, 8'h10, 1'b1);
        chk(!smp_doe && !smp_dir, "R7 write no drive", {smp_doe, smp_dir}, 2'b00);
        wait_free();
        chk(mem_addr == 13'(model_addr), "R7 address select read ignored", mem_addr, model_addr);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule